// File: doc/BRIEF.md
# Exception Return Status Unit

This unit performs the status-word update that a processor core applies when it returns from an exception or from a non-maskable interrupt. The core presents its current 32-bit condition/status word, the active stack pointer and the user stack pointer, and pulses one of two command strobes for one cycle. One of them returns from an exception and the other returns from a non-maskable interrupt.

The previous mode is not popped from a stack. It is recovered by shifting a masked copy of the status word right, which drops the current mode fields into place. The two top bits survive unchanged and a fixed window below them is cleared. Two flags are then adjusted. The pending flag depends on the restart flag as it stood before the shift. A return from a non-maskable interrupt also forces the NMI-mask flag on. When the recovered word selects user mode, the unit saves the live stack pointer as the kernel stack pointer and loads the stack pointer from the user copy.

All results are registered and appear one cycle after the strobe, together with a one-cycle completion pulse.

Top module: `exc_ret_status`

## Requirements
- R1: Bits 31:30 of the new status word equal bits 31:30 of the status word sampled with the command.
- R2: Bits 29:18 of the new status word are zero, so old bits 29:28 never appear in the result.
- R3: Bits 17:0 of the new status word equal old bits 27:10, except for the adjustments of R4 and R7.
- R4: The pending flag (bit 7) is set when the old restart flag (bit 8, before the shift) is 0. Otherwise bit 7 keeps the shifted value, which is old bit 17.
- R5: When the user flag (bit 6) of the shifted word is 1 (old bit 16), the unit does three things one cycle later. It pulses swap_o, sets ksp_o to the sampled sp_i, and sets sp_o to the sampled usp_i.
- R6: When the shifted user flag is 0, or when no command is given, sp_o and ksp_o keep their values and swap_o stays 0.
- R7: A return from a non-maskable interrupt (rfn_i) forces the NMI-mask flag (bit 9) to 1. A return from an exception (rfe_i) leaves bit 9 as shifted, which is old bit 19.
- R8: When rfe_i and rfn_i are both high, the command is treated as rfn_i.
- R9: done_o is high exactly one cycle after a cycle with rfe_i or rfn_i high. With no command, ccs_o keeps its value whatever ccs_i does.
- R10: While rst_ni is low, ccs_o, sp_o and ksp_o are zero and done_o and swap_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rfe_i | input | 1 | One-cycle strobe: return from exception |
| rfn_i | input | 1 | One-cycle strobe: return from non-maskable interrupt |
| ccs_i | input | 32 | Current status word |
| sp_i | input | 32 | Current stack pointer |
| usp_i | input | 32 | User stack pointer |
| ccs_o | output | 32 | Updated status word (registered) |
| sp_o | output | 32 | Stack pointer after a possible swap |
| ksp_o | output | 32 | Saved kernel stack pointer |
| done_o | output | 1 | One-cycle pulse when ccs_o is updated |
| swap_o | output | 1 | One-cycle pulse when a stack swap took place |

## Verification
The bench builds the unit with its default parameters: a 32-bit word, two kept top bits, a 10-bit shift, and flags at bits 6 to 9. With these values the user flag comes from old bit 16, and the restart flag at bit 8 is read before the shift, which makes the pending-flag dependence observable. Random status words hit every combination of old bits 8, 16, 17 and 19. Directed cases cover the all-ones and all-zeros words, both strobes together, and idle cycles in which ccs_i moves while the outputs must stay put.

// File: rtl/erst_pkg.sv
package erst_pkg;
  typedef enum logic [1:0] {
    CMD_NONE = 2'd0,
    CMD_RFE  = 2'd1,
    CMD_RFN  = 2'd2
  } erst_cmd_e;

  function automatic erst_cmd_e decode_cmd(input logic rfe, input logic rfn);
    // rfn wins over rfe
    if (rfn)      return CMD_RFN;
    else if (rfe) return CMD_RFE;
    else          return CMD_NONE;
  endfunction
endpackage

// File: rtl/erst_shift.sv
module erst_shift #(
  parameter int W      = 32,
  parameter int KEEP_W = 2,
  parameter int GAP_W  = 2,
  parameter int SHIFT  = 10
) (
  input  logic [W-1:0] word_i,
  output logic [W-1:0] word_o
);
  localparam int LOW_W = W - KEEP_W - GAP_W;
  localparam logic [W-1:0] KEEP_MASK = {{KEEP_W{1'b1}}, {(W-KEEP_W){1'b0}}};
  localparam logic [W-1:0] LOW_MASK  = {{(KEEP_W+GAP_W){1'b0}}, {LOW_W{1'b1}}};

  always_comb begin
    word_o = (word_i & KEEP_MASK) | ((word_i & LOW_MASK) >> SHIFT);
  end
endmodule

// File: rtl/erst_flag_fix.sv
module erst_flag_fix #(
  parameter int W     = 32,
  parameter int P_BIT = 7,
  parameter int M_BIT = 9
) (
  input  logic [W-1:0] shifted_i,
  input  logic         old_r_i,
  input  logic         is_rfn_i,
  output logic [W-1:0] word_o
);
  always_comb begin
    word_o = shifted_i;
    if (!old_r_i) word_o[P_BIT] = 1'b1;
    if (is_rfn_i) word_o[M_BIT] = 1'b1;
  end
endmodule

// File: rtl/erst_sp_swap.sv
module erst_sp_swap #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         go_i,
  input  logic         user_i,
  input  logic [W-1:0] sp_i,
  input  logic [W-1:0] usp_i,
  output logic [W-1:0] sp_o,
  output logic [W-1:0] ksp_o,
  output logic         swap_o
);
  logic do_swap;
  assign do_swap = go_i & user_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_o   <= '0;
      ksp_o  <= '0;
      swap_o <= 1'b0;
    end else begin
      swap_o <= do_swap;
      if (do_swap) begin
        ksp_o <= sp_i;
        sp_o  <= usp_i;
      end
    end
  end
endmodule

// File: rtl/exc_ret_status.sv
module exc_ret_status #(
  parameter int W      = 32,
  parameter int KEEP_W = 2,
  parameter int GAP_W  = 2,
  parameter int SHIFT  = 10,
  parameter int U_BIT  = 6,
  parameter int P_BIT  = 7,
  parameter int R_BIT  = 8,
  parameter int M_BIT  = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         rfe_i,
  input  logic         rfn_i,
  input  logic [W-1:0] ccs_i,
  input  logic [W-1:0] sp_i,
  input  logic [W-1:0] usp_i,
  output logic [W-1:0] ccs_o,
  output logic [W-1:0] sp_o,
  output logic [W-1:0] ksp_o,
  output logic         done_o,
  output logic         swap_o
);
  import erst_pkg::*;

  erst_cmd_e    cmd;
  logic         go;
  logic [W-1:0] shifted;
  logic [W-1:0] fixed;

  assign cmd = decode_cmd(rfe_i, rfn_i);
  assign go  = (cmd != CMD_NONE);

  erst_shift #(.W(W), .KEEP_W(KEEP_W), .GAP_W(GAP_W), .SHIFT(SHIFT)) u_shift (
    .word_i (ccs_i),
    .word_o (shifted)
  );

  erst_flag_fix #(.W(W), .P_BIT(P_BIT), .M_BIT(M_BIT)) u_fix (
    .shifted_i (shifted),
    .old_r_i   (ccs_i[R_BIT]),
    .is_rfn_i  (cmd == CMD_RFN),
    .word_o    (fixed)
  );

  erst_sp_swap #(.W(W)) u_swap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .go_i   (go),
    .user_i (shifted[U_BIT]),
    .sp_i   (sp_i),
    .usp_i  (usp_i),
    .sp_o   (sp_o),
    .ksp_o  (ksp_o),
    .swap_o (swap_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ccs_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= go;
      if (go) ccs_o <= fixed;
    end
  end
endmodule

// File: rtl/exc_ret_status_chk.sv
module exc_ret_status_chk #(
  parameter int W      = 32,
  parameter int KEEP_W = 2,
  parameter int GAP_W  = 2,
  parameter int SHIFT  = 10,
  parameter int P_BIT  = 7,
  parameter int R_BIT  = 8,
  parameter int M_BIT  = 9
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         rfe_i,
  input logic         rfn_i,
  input logic [W-1:0] ccs_i,
  input logic [W-1:0] sp_i,
  input logic [W-1:0] usp_i,
  input logic [W-1:0] ccs_o,
  input logic [W-1:0] sp_o,
  input logic [W-1:0] ksp_o,
  input logic         done_o,
  input logic         swap_o
);
  localparam int GAP_LO = W - KEEP_W - GAP_W - SHIFT;
  localparam int GAP_HI = W - KEEP_W - 1;

  a_r1_keep_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfe_i || rfn_i) |=> ccs_o[W-1:W-KEEP_W] == $past(ccs_i[W-1:W-KEEP_W]));

  a_r2_gap_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ccs_o[GAP_HI:GAP_LO] == '0);

  a_r4_pending_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((rfe_i || rfn_i) && !ccs_i[R_BIT]) |=> ccs_o[P_BIT]);

  a_r7_rfn_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rfn_i |=> ccs_o[M_BIT]);

  a_r5_swap_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap_o |-> (sp_o == $past(usp_i) && ksp_o == $past(sp_i)));

  a_r6_sp_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !swap_o |-> ($stable(sp_o) && $stable(ksp_o)));

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfe_i || rfn_i) |=> done_o);

  a_r9_ccs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rfe_i || rfn_i) |=> (!done_o && !swap_o && $stable(ccs_o)));
endmodule

bind exc_ret_status exc_ret_status_chk #(
  .W(W), .KEEP_W(KEEP_W), .GAP_W(GAP_W), .SHIFT(SHIFT),
  .P_BIT(P_BIT), .R_BIT(R_BIT), .M_BIT(M_BIT)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .rfe_i  (rfe_i),
  .rfn_i  (rfn_i),
  .ccs_i  (ccs_i),
  .sp_i   (sp_i),
  .usp_i  (usp_i),
  .ccs_o  (ccs_o),
  .sp_o   (sp_o),
  .ksp_o  (ksp_o),
  .done_o (done_o),
  .swap_o (swap_o)
);

// File: tb/exc_ret_status_test.sv
`timescale 1ns/1ps
module exc_ret_status_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rfe_i = 1'b0;
  logic        rfn_i = 1'b0;
  logic [31:0] ccs_i = '0;
  logic [31:0] sp_i = '0;
  logic [31:0] usp_i = '0;
  logic [31:0] ccs_o, sp_o, ksp_o;
  logic        done_o, swap_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_sp = '0;
  logic [31:0] m_ksp = '0;
  logic [31:0] m_ccs = '0;

  always #4 clk_i = ~clk_i;

  exc_ret_status uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .rfe_i(rfe_i), .rfn_i(rfn_i),
    .ccs_i(ccs_i), .sp_i(sp_i), .usp_i(usp_i),
    .ccs_o(ccs_o), .sp_o(sp_o), .ksp_o(ksp_o),
    .done_o(done_o), .swap_o(swap_o)
  );

  // expected status word: rfn has priority when both strobes are high
  function automatic logic [31:0] exp_ccs(input logic rfe, input logic rfn,
                                          input logic [31:0] c);
    logic [31:0] s;
    s = {c[31:30], 12'b0, c[27:10]};
    if (!c[8]) s[7] = 1'b1;
    if (rfn)   s[9] = 1'b1;
    else if (!rfe) s = c;
    return s;
  endfunction

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic rfe, input logic rfn, input logic [31:0] c,
                       input logic [31:0] sp, input logic [31:0] usp);
    logic [31:0] e;
    logic        sw;
    @(negedge clk_i);
    rfe_i = rfe; rfn_i = rfn; ccs_i = c; sp_i = sp; usp_i = usp;
    e  = exp_ccs(rfe, rfn, c);
    sw = (rfe || rfn) && c[16];
    if (rfe || rfn) m_ccs = e;
    if (sw) begin m_ksp = sp; m_sp = usp; end
    @(negedge clk_i);
    rfe_i = 1'b0; rfn_i = 1'b0;
    ccs_i = $urandom;
    // R1 R2 R3 R4 R7 R8 status word
    check("R1/R2/R3/R4/R7/R8 ccs", ccs_o, m_ccs);
    check("R9 done", {31'b0, done_o}, {31'b0, (rfe || rfn)});
    check("R5/R6 swap", {31'b0, swap_o}, {31'b0, sw});
    check("R5/R6 sp", sp_o, m_sp);
    check("R5/R6 ksp", ksp_o, m_ksp);
  endtask

  task automatic idle_check();
    @(negedge clk_i);
    ccs_i = ~ccs_i; sp_i = $urandom; usp_i = $urandom;
    @(negedge clk_i);
    check("R9 hold ccs", ccs_o, m_ccs);
    check("R9 no done", {31'b0, done_o}, 32'd0);
    check("R6 hold sp", sp_o, m_sp);
    check("R6 hold ksp", ksp_o, m_ksp);
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #1;
    // R10 reset state
    check("R10 ccs", ccs_o, 32'd0);
    check("R10 sp", sp_o, 32'd0);
    check("R10 ksp", ksp_o, 32'd0);
    check("R10 flags", {30'b0, done_o, swap_o}, 32'd0);
    #20 rst_ni = 1'b1;

    // directed corners
    issue(1'b1, 1'b0, 32'hFFFF_FFFF, 32'h1111_0000, 32'h2222_0000); // R4 R restored, R5 swap
    issue(1'b0, 1'b1, 32'h0000_0000, 32'h3333_0000, 32'h4444_0000); // R4 P set, R7 M forced, R6
    issue(1'b1, 1'b1, 32'h3000_0000, 32'h5555_0000, 32'h6666_0000); // R8 both, R2 bits 29:28 dropped
    issue(1'b1, 1'b0, 32'h0001_0100, 32'h7777_0000, 32'h8888_0000); // R5 user, R set -> P from bit 17
    issue(1'b1, 1'b0, 32'h0008_0000, 32'h0, 32'h0);                  // R7 rfe keeps M from bit 19
    idle_check();
    issue(1'b0, 1'b1, 32'hC002_0100, 32'h9, 32'hA);                   // R1 top bits, R4 P from bit 17
    idle_check();

    for (int i = 0; i < 300; i++) begin
      logic [1:0] k;
      k = 2'($urandom);
      if (k == 2'd0) idle_check();
      else issue(k[0], k[1], $urandom, $urandom, $urandom);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule